// File: doc/BRIEF.md
# Clamped Fixed-Point PI Loop Regulator

This block is the loop filter of a sampled phase-locked loop. Each time `smp_valid` is high for a clock it takes one signed error sample and produces one signed actuator word. That word is proportional-plus-integral in the error, scaled down by a fixed number of fractional bits, offset by a programmable bias and limited to a programmable window. The word and a one-cycle `act_valid` flag leave a register one clock after the strobe. The last word is held until the next strobe.

The gains, bias, window limits and anti-windup enable are configuration inputs. They pass through a shadow register that loads only in cycles with no strobe, so software may change them at any time without tearing a sample. The integrator is cleared by reset or by the `clr_integ` pulse. While the output is pinned at a limit, anti-windup lets the integrator move only back toward the window. With anti-windup off, the integrator always follows the error.

Top module: `clamp_pi_filter`

## Requirements
- R1: After reset, `act_valid` is 0, `act_value` is 0 and the integrator is zero, so the first sample sees an empty integrator.
- R2: A strobe with `clr_integ` low makes `act_valid` high for exactly the following clock. `act_value` changes only on that clock and holds its value in every other cycle.
- R3: The unclamped result is ((I + e)·ki + e·kp) shifted right arithmetically by FRAC bits (rounding toward minus infinity), plus bias. I is the stored integrator, e is the sign-extended error, and FRAC is 12 by default.
- R4: A result below the low limit is output as the low limit. A result above the high limit is output as the high limit.
- R5: When the result lies inside the window, the integrator becomes I + e.
- R6: With anti-windup disabled, the integrator becomes I + e even when the output is clamped.
- R7: With anti-windup enabled and the output clamped at the low limit, the integrator becomes I + e only if I + e > I. Otherwise it keeps its value.
- R8: With anti-windup enabled and the output clamped at the high limit, the integrator becomes I + e only if I + e < I. Otherwise it keeps its value.
- R9: A `clr_integ` pulse zeroes the integrator. A strobe in the same cycle is discarded: no `act_valid`, and `act_value` is unchanged.
- R10: A sample uses the configuration present in the last clock cycle before it in which `smp_valid` was low. A configuration change made in a strobe cycle applies from the next sample.
- R11: Intermediate products are formed at full width. Gains and errors at their signed extremes therefore give a correctly clamped output with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_integ | input | 1 | Integrator clear pulse |
| smp_valid | input | 1 | Error sample strobe |
| smp_err | input | ERR_W (16) | Signed error sample |
| cfg_kp | input | GAIN_W (16) | Signed proportional gain, FRAC fractional bits |
| cfg_ki | input | GAIN_W (16) | Signed integral gain, FRAC fractional bits |
| cfg_bias | input | OUT_W (20) | Signed constant added after scaling |
| cfg_lo | input | OUT_W (20) | Signed low output limit |
| cfg_hi | input | OUT_W (20) | Signed high output limit |
| cfg_aw_en | input | 1 | Anti-windup enable |
| act_valid | output | 1 | Output word valid, one clock |
| act_value | output | OUT_W (20) | Signed clamped actuator word |

## Verification
The bench builds the block with its default parameters: 16-bit error and gains, a 24-bit integrator, a 20-bit output and 12 fractional bits. These values let a gain of exactly 1.0 (4096) make the integrator directly visible at the output. They also let a unit integral gain on an error of -1 expose the rounding direction of the shift. Extreme gains at ±32767 push the full-width product far beyond the 20-bit output, so any narrowed or wrapped intermediate shows up as a wrong clamp. Each anti-windup branch is followed by a sample at zero gain offset, which reveals whether the integrator moved.

// File: rtl/pi_pkg.sv
package pi_pkg;

  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_LOW  = 2'd1,
    CLAMP_HIGH = 2'd2
  } clamp_e;

  // Decide whether the integrator may take its candidate value.
  function automatic logic f_accept(input clamp_e cl, input logic aw_en,
                                    input logic cand_gt, input logic cand_lt);
    logic ok;
    case (cl)
      CLAMP_LOW:  ok = !aw_en || cand_gt;
      CLAMP_HIGH: ok = !aw_en || cand_lt;
      default:    ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pi_cfg_shadow.sv
module pi_cfg_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic [W-1:0] cfg_d,
  output logic [W-1:0] cfg_q
);
  // Configuration is captured only in cycles without a sample strobe.
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (!busy) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/pi_datapath.sv
module pi_datapath #(
  parameter int ERR_W  = 16,
  parameter int GAIN_W = 16,
  parameter int OUT_W  = 20,
  parameter int ACC_W  = 24,
  parameter int FRAC   = 12
) (
  input  logic signed [ACC_W-1:0]  integ_q,
  input  logic signed [ERR_W-1:0]  err,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic signed [OUT_W-1:0]  bias,
  input  logic signed [OUT_W-1:0]  lo,
  input  logic signed [OUT_W-1:0]  hi,
  output logic signed [ACC_W-1:0]  cand,
  output logic signed [OUT_W-1:0]  y_sat,
  output pi_pkg::clamp_e           clamp
);
  localparam int PW = ACC_W + GAIN_W + 1;

  // Full-width multiply-accumulate followed by an arithmetic down-shift.
  function automatic logic signed [PW-1:0] f_mac(
    input logic signed [ACC_W-1:0]  c,
    input logic signed [ERR_W-1:0]  e,
    input logic signed [GAIN_W-1:0] gi,
    input logic signed [GAIN_W-1:0] gp);
    logic signed [PW-1:0] cx, ex, gix, gpx, acc;
    cx  = c;
    ex  = e;
    gix = gi;
    gpx = gp;
    acc = cx * gix + ex * gpx;
    return acc >>> FRAC;
  endfunction

  function automatic logic signed [PW-1:0] f_widen(input logic signed [OUT_W-1:0] v);
    logic signed [PW-1:0] r;
    r = v;
    return r;
  endfunction

  logic signed [ACC_W-1:0] err_x;
  logic signed [PW-1:0]    raw;
  logic signed [PW-1:0]    lo_x, hi_x;

  assign err_x = err;
  assign cand  = integ_q + err_x;
  assign raw   = f_mac(cand, err, ki, kp) + f_widen(bias);
  assign lo_x  = f_widen(lo);
  assign hi_x  = f_widen(hi);

  always_comb begin
    if (raw < lo_x) begin
      clamp = pi_pkg::CLAMP_LOW;
      y_sat = lo;
    end else if (raw > hi_x) begin
      clamp = pi_pkg::CLAMP_HIGH;
      y_sat = hi;
    end else begin
      clamp = pi_pkg::CLAMP_NONE;
      y_sat = raw[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/pi_integrator.sv
module pi_integrator #(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    step,
  input  logic                    aw_en,
  input  pi_pkg::clamp_e          clamp,
  input  logic signed [ACC_W-1:0] cand,
  output logic signed [ACC_W-1:0] integ_q,
  output logic                    integ_load
);
  assign integ_load = step &&
    pi_pkg::f_accept(clamp, aw_en, cand > integ_q, cand < integ_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) integ_q <= '0;
    else if (integ_load) integ_q <= cand;
  end
endmodule

// File: rtl/clamp_pi_filter.sv
module clamp_pi_filter #(
  parameter int ERR_W  = 16,
  parameter int GAIN_W = 16,
  parameter int OUT_W  = 20,
  parameter int ACC_W  = 24,
  parameter int FRAC   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_integ,
  input  logic                     smp_valid,
  input  logic signed [ERR_W-1:0]  smp_err,
  input  logic signed [GAIN_W-1:0] cfg_kp,
  input  logic signed [GAIN_W-1:0] cfg_ki,
  input  logic signed [OUT_W-1:0]  cfg_bias,
  input  logic signed [OUT_W-1:0]  cfg_lo,
  input  logic signed [OUT_W-1:0]  cfg_hi,
  input  logic                     cfg_aw_en,
  output logic                     act_valid,
  output logic signed [OUT_W-1:0]  act_value
);
  localparam int CFG_W = 2 * GAIN_W + 3 * OUT_W + 1;

  logic [CFG_W-1:0]         cfg_d, cfg_q;
  logic signed [GAIN_W-1:0] kp_q, ki_q;
  logic signed [OUT_W-1:0]  bias_q, lo_q, hi_q;
  logic                     aw_q;
  logic signed [ACC_W-1:0]  integ_q, cand_w;
  logic signed [OUT_W-1:0]  y_sat;
  pi_pkg::clamp_e           clamp;
  logic                     step_go, integ_load, clamp_lo, clamp_hi;

  assign cfg_d = {cfg_kp, cfg_ki, cfg_bias, cfg_lo, cfg_hi, cfg_aw_en};
  assign {kp_q, ki_q, bias_q, lo_q, hi_q, aw_q} = cfg_q;

  pi_cfg_shadow #(.W(CFG_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .busy(smp_valid), .cfg_d(cfg_d), .cfg_q(cfg_q)
  );

  pi_datapath #(
    .ERR_W(ERR_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .ACC_W(ACC_W), .FRAC(FRAC)
  ) u_path (
    .integ_q(integ_q), .err(smp_err), .kp(kp_q), .ki(ki_q), .bias(bias_q),
    .lo(lo_q), .hi(hi_q), .cand(cand_w), .y_sat(y_sat), .clamp(clamp)
  );

  assign step_go  = smp_valid && !clr_integ;
  assign clamp_lo = (clamp == pi_pkg::CLAMP_LOW);
  assign clamp_hi = (clamp == pi_pkg::CLAMP_HIGH);

  pi_integrator #(.ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr_integ), .step(step_go), .aw_en(aw_q),
    .clamp(clamp), .cand(cand_w), .integ_q(integ_q), .integ_load(integ_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_value <= '0;
    end else begin
      act_valid <= step_go;
      if (step_go) act_value <= y_sat;
    end
  end
endmodule

// File: rtl/pi_filter_checker.sv
module pi_filter_checker #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr_integ,
  input logic                    smp_valid,
  input logic                    act_valid,
  input logic signed [OUT_W-1:0] act_value,
  input logic signed [OUT_W-1:0] lo_q,
  input logic signed [OUT_W-1:0] hi_q,
  input logic                    aw_q,
  input logic signed [ACC_W-1:0] cand_w,
  input logic signed [ACC_W-1:0] integ_q,
  input logic                    clamp_lo,
  input logic                    clamp_hi,
  input logic                    integ_load
);
  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !clr_integ) |=> act_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && !clr_integ) |=> !act_valid);

  a_r2_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(act_value));

  a_r4_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !clr_integ && lo_q <= hi_q) |=>
      (act_value >= $past(lo_q) && act_value <= $past(hi_q)));

  a_r5_follow_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !clr_integ && (!aw_q || (!clamp_lo && !clamp_hi))) |=>
      integ_q == $past(cand_w));

  a_r7_low_windup: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !clr_integ && aw_q && clamp_lo && !(cand_w > integ_q)) |=>
      $stable(integ_q));

  a_r8_high_windup: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !clr_integ && aw_q && clamp_hi && !(cand_w < integ_q)) |=>
      $stable(integ_q));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_integ |=> (integ_q == '0 && !act_valid));

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> ($stable(lo_q) && $stable(hi_q) && $stable(aw_q)));

  a_r9_no_load_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_integ |-> !integ_load);
endmodule

bind clamp_pi_filter pi_filter_checker #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_integ(clr_integ), .smp_valid(smp_valid),
  .act_valid(act_valid), .act_value(act_value), .lo_q(lo_q), .hi_q(hi_q),
  .aw_q(aw_q), .cand_w(cand_w), .integ_q(integ_q), .clamp_lo(clamp_lo),
  .clamp_hi(clamp_hi), .integ_load(integ_load)
);

// File: tb/clamp_pi_filter_tb.sv
`timescale 1ns/1ps
module clamp_pi_filter_tb;
  localparam int ERR_W = 16, GAIN_W = 16, OUT_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_integ = 1'b0, smp_valid = 1'b0, cfg_aw_en = 1'b0;
  logic signed [ERR_W-1:0]  smp_err = '0;
  logic signed [GAIN_W-1:0] cfg_kp = '0, cfg_ki = '0;
  logic signed [OUT_W-1:0]  cfg_bias = '0, cfg_lo = '0, cfg_hi = '0;
  logic act_valid;
  logic signed [OUT_W-1:0] act_value;

  int checks = 0;
  int errors = 0;

  // Bench mirror of the effective configuration and integrator.
  longint m_kp, m_ki, m_bias, m_lo, m_hi, m_integ;
  bit     m_aw;

  always #10 clk = ~clk;

  clamp_pi_filter u_dut (
    .clk(clk), .rst_n(rst_n), .clr_integ(clr_integ), .smp_valid(smp_valid),
    .smp_err(smp_err), .cfg_kp(cfg_kp), .cfg_ki(cfg_ki), .cfg_bias(cfg_bias),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_aw_en(cfg_aw_en),
    .act_valid(act_valid), .act_value(act_value)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Reference step: returns expected output, updates the mirrored integrator.
  task automatic model(input longint e, output longint y);
    longint c, raw;
    c   = m_integ + e;
    raw = ((c * m_ki + e * m_kp) >>> 12) + m_bias;
    if (raw < m_lo) begin
      y = m_lo;
      if (!m_aw || c > m_integ) m_integ = c;
    end else if (raw > m_hi) begin
      y = m_hi;
      if (!m_aw || c < m_integ) m_integ = c;
    end else begin
      y = raw;
      m_integ = c;
    end
  endtask

  task automatic set_cfg(input longint kp, ki, bias, lo, hi, input bit aw);
    @(negedge clk);
    cfg_kp = GAIN_W'(kp); cfg_ki = GAIN_W'(ki); cfg_bias = OUT_W'(bias);
    cfg_lo = OUT_W'(lo); cfg_hi = OUT_W'(hi); cfg_aw_en = aw;
    m_kp = kp; m_ki = ki; m_bias = bias; m_lo = lo; m_hi = hi; m_aw = aw;
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr_integ = 1'b1;
    @(negedge clk); clr_integ = 1'b0;
    m_integ = 0;
  endtask

  task automatic send(input string req, input longint e);
    longint y;
    @(negedge clk); smp_valid = 1'b1; smp_err = ERR_W'(e);
    @(negedge clk); smp_valid = 1'b0;
    model(e, y);
    chk(req, longint'(act_valid), 1);
    chk(req, longint'(act_value), y);
  endtask

  task automatic t_reset();
    chk("R1 valid", longint'(act_valid), 0);
    chk("R1 value", longint'(act_value), 0);
    set_cfg(0, 4096, 0, -100000, 100000, 0);
    send("R1 empty integrator", 37);
  endtask

  task automatic t_basic();
    longint held;
    do_clear();
    set_cfg(8192, 4096, 100, -100000, 100000, 0);
    send("R3 R5 basic", 10);
    send("R3 R5 basic", -3);
    send("R3 R5 basic", 7);
    held = longint'(act_value);
    @(negedge clk);
    chk("R2 valid drops", longint'(act_valid), 0);
    chk("R2 value holds", longint'(act_value), held);
    repeat (3) @(negedge clk);
    chk("R2 value still held", longint'(act_value), held);
  endtask

  task automatic t_shift();
    do_clear();
    set_cfg(0, 1, 0, -100000, 100000, 0);
    send("R3 arith shift", -1);
    send("R3 arith shift", -4096);
    set_cfg(3000, 5000, -7, -100000, 100000, 0);
    send("R3 mixed", 1234);
    send("R3 mixed", -2222);
  endtask

  task automatic t_clamp_noaw();
    do_clear();
    set_cfg(0, 4096, 0, -1000, 50, 0);
    send("R4 R6 clamp high", 100);
    send("R6 integ took value", -60);
    send("R4 R6 clamp low", -2000);
    send("R6 integ took value", 1500);
  endtask

  task automatic t_aw_high();
    do_clear();
    set_cfg(0, 4096, 0, -1000, 50, 1);
    send("R8 clamp high growing", 100);
    send("R8 integ frozen", -60);
    do_clear();
    set_cfg(0, 4096, 100, -1000, 50, 1);
    send("R8 clamp high shrinking", -10);
    set_cfg(0, 4096, 0, -1000, 50, 1);
    send("R8 integ moved", 0);
  endtask

  task automatic t_aw_low();
    do_clear();
    set_cfg(0, 4096, -1000, -500, 500, 1);
    send("R7 clamp low falling", -10);
    send("R7 clamp low rising", 20);
    set_cfg(0, 4096, 0, -500, 500, 1);
    send("R7 integ after low", 0);
  endtask

  task automatic t_clear();
    longint held;
    set_cfg(0, 4096, 0, -100000, 100000, 0);
    send("R9 preload", 900);
    held = longint'(act_value);
    @(negedge clk); clr_integ = 1'b1; smp_valid = 1'b1; smp_err = 16'sd500;
    @(negedge clk); clr_integ = 1'b0; smp_valid = 1'b0;
    m_integ = 0;
    chk("R9 strobe dropped", longint'(act_valid), 0);
    chk("R9 value unchanged", longint'(act_value), held);
    send("R9 integ zeroed", 0);
  endtask

  task automatic t_cfg_timing();
    longint y;
    do_clear();
    set_cfg(0, 4096, 0, -100000, 100000, 0);
    @(negedge clk); smp_valid = 1'b1; smp_err = 16'sd40; cfg_ki = 16'sd8192;
    @(negedge clk); smp_valid = 1'b0;
    model(40, y);
    chk("R10 old gain used", longint'(act_value), y);
    m_ki = 8192;
    send("R10 new gain used", 40);
  endtask

  task automatic t_extremes();
    do_clear();
    set_cfg(32767, 32767, 0, -524288, 524287, 0);
    send("R11 big positive", 32767);
    send("R11 big positive", 32767);
    send("R11 big negative", -32768);
    send("R11 big negative", -32768);
    send("R11 big negative", -32768);
    send("R11 big negative", -32768);
    set_cfg(-32768, -32768, 0, -524288, 524287, 0);
    send("R11 negative gains", 32767);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_integ = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_shift();
    t_clamp_noaw();
    t_aw_high();
    t_aw_low();
    t_clear();
    t_cfg_timing();
    t_extremes();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule